// File: doc/BRIEF.md
# Instruction Cache Command and Status Unit

This unit is the software-facing control port of an instruction cache. It holds three registers: a control/status register, a line address register and a data register. A supervisor write of a command code to the control/status register starts an operation on the cache core. The operations are invalidate all, invalidate line, unlock line, unlock all and load-and-lock. Every operation except load-and-lock finishes in the cycle it is issued and cannot fail.

Load-and-lock stays outstanding until the core answers with a done pulse. While it is outstanding, a busy bit is set and register writes are held off. If the core reports a failure with its done pulse, a sticky error bit is set. Software clears that bit by writing 1 to it, so a series of lock commands can be checked with a single read.

A separate block-invalidate request path serves the plain user-level instruction for invalidating one cache line. This path needs no privilege. It acts only on the local cache core and produces nothing beyond the core command port.

Top module: `icache_cmd_ctrl`

## Requirements
- R1: After reset, all three registers read 0, busy is 0, and no core command is issued.
- R2: A supervisor write to the control/status register (select 0) with bits [3:0] equal to 1 (invalidate all), 2 (invalidate line), 4 (unlock line) or 5 (unlock all) produces the following core outputs in the cycle after the write: core_cmd_valid high for exactly that cycle, core_cmd equal to the code, and core_addr equal to the address register. None of these commands sets busy or an error bit.
- R3: A supervisor write of code 3 (load-and-lock) produces the following, starting in the cycle after the write:
  - core_cmd_valid is high for one cycle with core_cmd equal to 3.
  - Status bit 8 (busy) is high.
  - Busy clears in the cycle after core_done is sampled high.
- R4: When core_done and core_err are high while busy, the unit sets a sticky error bit. It sets bit 9 when core_err_kind is 0 (bus fault) and bit 10 when core_err_kind is 1 (no lockable way). These bits stay set across later commands.
- R5: A control/status write clears bits 9 and 10 only where the written bit is 1. A written 0 leaves the bit unchanged.
- R6: A write with reg_super low changes no register and issues no command. A read with reg_super low returns 0.
- R7: A block-invalidate request is accepted at any privilege level when not busy. In the next cycle it issues core_cmd 2 with core_addr equal to blk_inv_addr. While busy, blk_inv_stall is high and the request is not taken.
- R8: reg_stall is high while busy or while blk_inv_req is high, and no register write is taken while reg_stall is high.
- R9: Command codes 0 and 6 to 15 issue no core command and set no error bit.
- R10: The address register (select 1) holds AW bits and reads back zero-extended. The data register (select 2) holds DW bits, reads back unchanged and drives core_wdata.
- R11: A core_done pulse while not busy sets no error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control/status, 1 address, 2 data |
| reg_wdata | input | DW | Register write data |
| reg_super | input | 1 | High for a supervisor-level access |
| reg_rdata | output | DW | Read data of the selected register |
| reg_stall | output | 1 | Register writes are not taken |
| blk_inv_req | input | 1 | Block-invalidate request, any privilege |
| blk_inv_addr | input | AW | Line address for block invalidate |
| blk_inv_stall | output | 1 | Block-invalidate request not taken |
| core_cmd_valid | output | 1 | One-cycle command strobe to the cache core |
| core_cmd | output | 4 | Operation code to the cache core |
| core_addr | output | AW | Line address of the operation |
| core_wdata | output | DW | Data register contents |
| core_done | input | 1 | Core finished a load-and-lock |
| core_err | input | 1 | Load-and-lock failed, valid with core_done |
| core_err_kind | input | 1 | Failure kind: 0 bus fault, 1 no lockable way |

## Verification
The bench builds the unit with DW = 32, AW = 20 and the load-and-lock variant enabled. The narrow address register makes the zero-extension of address reads visible: upper write bits are dropped and must read back as 0. With load-and-lock enabled, the bench reaches the busy window, stalled writes and blocked block-invalidate requests inside that window, both sticky error kinds, and a stray done pulse while idle.

// File: rtl/icc_pkg.sv
package icc_pkg;
   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_ADDR = 2'd1;
   localparam logic [1:0] SEL_DATA = 2'd2;

   typedef enum logic [3:0] {
      CC_NONE        = 4'd0,
      CC_INV_ALL     = 4'd1,
      CC_INV_LINE    = 4'd2,
      CC_LOAD_LOCK   = 4'd3,
      CC_UNLOCK_LINE = 4'd4,
      CC_UNLOCK_ALL  = 4'd5
   } icc_code_e;

   localparam int CODE_W       = 4;
   localparam int BUSY_BIT     = 8;
   localparam int ERR_LSB      = 9;
   localparam int NUM_ERR      = 2;
   localparam int CTRL_MIN_W   = ERR_LSB + NUM_ERR;
endpackage

// File: rtl/icc_cmd_decode.sv
module icc_cmd_decode
   import icc_pkg::*;
#(
   parameter bit LOCK_EN = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   output logic              known,
   output logic              is_lock
);
   generate
      if (LOCK_EN) begin : g_with_lock
         always_comb begin
            known   = 1'b0;
            is_lock = 1'b0;
            case (code)
               CC_INV_ALL, CC_INV_LINE,
               CC_UNLOCK_LINE, CC_UNLOCK_ALL: known = 1'b1;
               CC_LOAD_LOCK: begin
                  known   = 1'b1;
                  is_lock = 1'b1;
               end
               default: known = 1'b0;
            endcase
         end
      end else begin : g_no_lock
         always_comb begin
            is_lock = 1'b0;
            case (code)
               CC_INV_ALL, CC_INV_LINE,
               CC_UNLOCK_LINE, CC_UNLOCK_ALL: known = 1'b1;
               default: known = 1'b0;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/icc_lock_track.sv
module icc_lock_track
   import icc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_lock,
   input  logic               done,
   input  logic               fail,
   input  logic               fail_kind,
   input  logic [NUM_ERR-1:0] clr_mask,
   output logic               busy,
   output logic [NUM_ERR-1:0] err_q
);
   logic [NUM_ERR-1:0] set_mask;

   always_comb begin
      set_mask = '0;
      if (busy && done && fail) set_mask[fail_kind] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         err_q <= '0;
      end else begin
         if (start_lock)      busy <= 1'b1;
         else if (done)       busy <= 1'b0;
         err_q <= (err_q & ~clr_mask) | set_mask;
      end
   end
endmodule

// File: rtl/icc_issue.sv
module icc_issue
   import icc_pkg::*;
#(
   parameter int AW = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_go,
   input  logic [CODE_W-1:0] reg_op,
   input  logic [AW-1:0]     reg_addr,
   input  logic              blk_go,
   input  logic [AW-1:0]     blk_addr,
   output logic              cmd_valid,
   output logic [CODE_W-1:0] cmd,
   output logic [AW-1:0]     addr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd       <= '0;
         addr      <= '0;
      end else begin
         cmd_valid <= blk_go | reg_go;
         if (blk_go) begin
            cmd  <= CC_INV_LINE;
            addr <= blk_addr;
         end else if (reg_go) begin
            cmd  <= reg_op;
            addr <= reg_addr;
         end
      end
   end
endmodule

// File: rtl/icache_cmd_ctrl.sv
module icache_cmd_ctrl
   import icc_pkg::*;
#(
   parameter int DW      = 32,
   parameter int AW      = 28,
   parameter bit LOCK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [DW-1:0]     reg_wdata,
   input  logic              reg_super,
   output logic [DW-1:0]     reg_rdata,
   output logic              reg_stall,
   input  logic              blk_inv_req,
   input  logic [AW-1:0]     blk_inv_addr,
   output logic              blk_inv_stall,
   output logic              core_cmd_valid,
   output logic [3:0]        core_cmd,
   output logic [AW-1:0]     core_addr,
   output logic [DW-1:0]     core_wdata,
   input  logic              core_done,
   input  logic              core_err,
   input  logic              core_err_kind
);
   localparam int PAD_W = DW - AW;

   if (DW < CTRL_MIN_W) begin : g_bad_dw
      $error("icache_cmd_ctrl: DW too small for status fields");
   end
   if (AW < 1 || AW >= DW) begin : g_bad_aw
      $error("icache_cmd_ctrl: AW must be in 1..DW-1");
   end

   logic               busy_q;
   logic [NUM_ERR-1:0] err_q;
   logic [AW-1:0]      addr_q;
   logic [DW-1:0]      data_q;
   logic               wr_take, ctrl_wr, code_known, code_lock;
   logic               reg_go, blk_go;
   logic [NUM_ERR-1:0] clr_mask;

   assign reg_stall     = busy_q | blk_inv_req;
   assign blk_inv_stall = busy_q;
   assign wr_take       = reg_wr & reg_super & ~reg_stall;
   assign ctrl_wr       = wr_take && (reg_sel == SEL_CTRL);
   assign reg_go        = ctrl_wr & code_known;
   assign blk_go        = blk_inv_req & ~busy_q;
   assign clr_mask      = ctrl_wr ? reg_wdata[ERR_LSB +: NUM_ERR] : '0;
   assign core_wdata    = data_q;

   icc_cmd_decode #(.LOCK_EN(LOCK_EN)) u_dec (
      .code    (reg_wdata[CODE_W-1:0]),
      .known   (code_known),
      .is_lock (code_lock)
   );

   icc_lock_track u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_lock (reg_go & code_lock),
      .done       (core_done),
      .fail       (core_err),
      .fail_kind  (core_err_kind),
      .clr_mask   (clr_mask),
      .busy       (busy_q),
      .err_q      (err_q)
   );

   icc_issue #(.AW(AW)) u_iss (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_go    (reg_go),
      .reg_op    (reg_wdata[CODE_W-1:0]),
      .reg_addr  (addr_q),
      .blk_go    (blk_go),
      .blk_addr  (blk_inv_addr),
      .cmd_valid (core_cmd_valid),
      .cmd       (core_cmd),
      .addr      (core_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (wr_take) begin
         if (reg_sel == SEL_ADDR) addr_q <= reg_wdata[AW-1:0];
         if (reg_sel == SEL_DATA) data_q <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_super) begin
         case (reg_sel)
            SEL_CTRL: begin
               reg_rdata[BUSY_BIT]              = busy_q;
               reg_rdata[ERR_LSB +: NUM_ERR]    = err_q;
            end
            SEL_ADDR: reg_rdata = {{PAD_W{1'b0}}, addr_q};
            SEL_DATA: reg_rdata = data_q;
            default:  reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/icc_cmd_chk.sv
module icc_cmd_chk
   import icc_pkg::*;
#(
   parameter int AW = 28
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy_q,
   input logic [NUM_ERR-1:0] err_q,
   input logic [AW-1:0]      addr_q,
   input logic               core_cmd_valid,
   input logic [3:0]         core_cmd,
   input logic               core_done,
   input logic               core_err,
   input logic               core_err_kind,
   input logic               reg_wr,
   input logic               reg_super
);
   assert_busy_starts_with_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (core_cmd_valid && core_cmd == 4'd3));

   assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !core_done) |=> busy_q);

   assert_no_issue_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> !core_cmd_valid);

   assert_bus_err_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q[0]) |-> $past(busy_q && core_done && core_err && !core_err_kind));

   assert_full_err_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q[1]) |-> $past(busy_q && core_done && core_err && core_err_kind));

   assert_user_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_super) |=> (addr_q == $past(addr_q)));
endmodule

bind icache_cmd_ctrl icc_cmd_chk #(.AW(AW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .busy_q         (busy_q),
   .err_q          (err_q),
   .addr_q         (addr_q),
   .core_cmd_valid (core_cmd_valid),
   .core_cmd       (core_cmd),
   .core_done      (core_done),
   .core_err       (core_err),
   .core_err_kind  (core_err_kind),
   .reg_wr         (reg_wr),
   .reg_super      (reg_super)
);

// File: tb/sim_icache_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_icache_cmd_ctrl;
   localparam int DW = 32;
   localparam int AW = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_super = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic reg_stall, blk_inv_stall;
   logic blk_inv_req = 1'b0;
   logic [AW-1:0] blk_inv_addr = '0;
   logic core_cmd_valid;
   logic [3:0] core_cmd;
   logic [AW-1:0] core_addr;
   logic [DW-1:0] core_wdata;
   logic core_done = 1'b0, core_err = 1'b0, core_err_kind = 1'b0;

   always #2.5 clk = ~clk;

   icache_cmd_ctrl #(.DW(DW), .AW(AW), .LOCK_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_super(reg_super), .reg_rdata(reg_rdata),
      .reg_stall(reg_stall), .blk_inv_req(blk_inv_req), .blk_inv_addr(blk_inv_addr),
      .blk_inv_stall(blk_inv_stall), .core_cmd_valid(core_cmd_valid),
      .core_cmd(core_cmd), .core_addr(core_addr), .core_wdata(core_wdata),
      .core_done(core_done), .core_err(core_err), .core_err_kind(core_err_kind));

   int n_cmp = 0, n_bad = 0, cycles = 0;
   string phase = "R1";
   bit started = 0;

   // behavioural reference model
   bit m_busy;
   bit [1:0] m_err;
   int unsigned m_addr, m_data;
   bit e_v;
   int unsigned e_op, e_addr;

   task automatic cmp(string what, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_err = 0; m_addr = 0; m_data = 0; e_v = 0; e_op = 0; e_addr = 0;
      end else begin
         bit stall;
         int unsigned code;
         stall = m_busy || blk_inv_req;
         e_v = 0;
         if (blk_inv_req && !m_busy) begin
            e_v = 1; e_op = 2; e_addr = blk_inv_addr;
         end
         if (core_done && m_busy) begin
            m_busy = 0;
            if (core_err) m_err[core_err_kind] = 1;
         end
         if (reg_wr && reg_super && !stall) begin
            if (reg_sel == 2'd1) m_addr = reg_wdata & ((1 << AW) - 1);
            else if (reg_sel == 2'd2) m_data = reg_wdata;
            else if (reg_sel == 2'd0) begin
               m_err = m_err & ~reg_wdata[10:9];
               code = reg_wdata[3:0];
               if (code >= 1 && code <= 5) begin
                  e_v = 1; e_op = code; e_addr = m_addr;
                  if (code == 3) m_busy = 1;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && started) begin
         int unsigned exp_rd;
         cmp("core_cmd_valid", core_cmd_valid, e_v);
         if (e_v) begin
            cmp("core_cmd", core_cmd, e_op);
            cmp("core_addr", core_addr, e_addr);
         end
         cmp("reg_stall", reg_stall, m_busy || blk_inv_req);
         cmp("blk_inv_stall", blk_inv_stall, m_busy);
         cmp("core_wdata", core_wdata, m_data);
         exp_rd = 0;
         if (reg_super) begin
            if (reg_sel == 2'd0) exp_rd = (m_err << 9) | (m_busy << 8);
            else if (reg_sel == 2'd1) exp_rd = m_addr;
            else if (reg_sel == 2'd2) exp_rd = m_data;
         end
         cmp("reg_rdata", reg_rdata, exp_rd);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 20000) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
      end
   end

   task automatic cyc();
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d, input logic sup);
      reg_wr = 1; reg_sel = sel; reg_wdata = d; reg_super = sup;
      cyc();
      reg_wr = 0;
   endtask

   task automatic rd_chk(input logic [1:0] sel, input logic sup, input logic [DW-1:0] exp);
      reg_sel = sel; reg_super = sup; #0.5;
      cmp("read", reg_rdata, exp);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      started = 1;
      cyc();
      phase = "R1";
      rd_chk(2'd0, 1, 0); rd_chk(2'd1, 1, 0); rd_chk(2'd2, 1, 0);
      cmp("core_cmd_valid reset", core_cmd_valid, 0);

      phase = "R10";
      wr(2'd1, 32'hFFF1_2345, 1);
      wr(2'd2, 32'hDEAD_BEEF, 1);
      rd_chk(2'd1, 1, 32'h0001_2345);
      rd_chk(2'd2, 1, 32'hDEAD_BEEF);
      cmp("core_wdata", core_wdata, 32'hDEAD_BEEF);

      phase = "R2";
      wr(2'd0, 32'h1, 1); wr(2'd0, 32'h2, 1); wr(2'd0, 32'h4, 1); wr(2'd0, 32'h5, 1);
      idle(2);
      rd_chk(2'd0, 1, 0);

      phase = "R9";
      wr(2'd0, 32'h0, 1); wr(2'd0, 32'h6, 1); wr(2'd0, 32'hF, 1); wr(2'd0, 32'h9, 1);
      idle(2);
      rd_chk(2'd0, 1, 0);

      phase = "R3";
      wr(2'd0, 32'h3, 1);
      rd_chk(2'd0, 1, 32'h100);
      idle(3);
      phase = "R8";
      wr(2'd1, 32'h0000_0ABC, 1);
      rd_chk(2'd1, 1, 32'h0001_2345);
      wr(2'd0, 32'h1, 1);
      phase = "R7";
      blk_inv_req = 1; blk_inv_addr = 20'h0_0777; cyc(); blk_inv_req = 0;
      phase = "R3";
      core_done = 1; cyc(); core_done = 0;
      rd_chk(2'd0, 1, 0);

      phase = "R4";
      wr(2'd0, 32'h3, 1); idle(2);
      core_done = 1; core_err = 1; core_err_kind = 0; cyc();
      core_done = 0; core_err = 0;
      rd_chk(2'd0, 1, 32'h200);
      wr(2'd0, 32'h3, 1); idle(1);
      core_done = 1; core_err = 1; core_err_kind = 1; cyc();
      core_done = 0; core_err = 0; core_err_kind = 0;
      wr(2'd0, 32'h1, 1);
      rd_chk(2'd0, 1, 32'h600);

      phase = "R6";
      wr(2'd0, 32'h0000_0601, 0);
      wr(2'd1, 32'h0000_0055, 0);
      wr(2'd2, 32'h1234_5678, 0);
      rd_chk(2'd0, 0, 0);
      rd_chk(2'd0, 1, 32'h600);
      rd_chk(2'd1, 1, 32'h0001_2345);

      phase = "R5";
      wr(2'd0, 32'h0000_0000, 1);
      rd_chk(2'd0, 1, 32'h600);
      wr(2'd0, 32'h0000_0200, 1);
      rd_chk(2'd0, 1, 32'h400);
      wr(2'd0, 32'h0000_0400, 1);
      rd_chk(2'd0, 1, 0);

      phase = "R7";
      reg_super = 0; blk_inv_req = 1; blk_inv_addr = 20'hA_BCDE;
      reg_wr = 1; reg_sel = 2'd0; reg_wdata = 32'h1; cyc();
      reg_wr = 0; blk_inv_req = 0;
      cmp("core_cmd", core_cmd, 2);
      cmp("core_addr", core_addr, 20'hA_BCDE);
      reg_super = 1; blk_inv_req = 1; blk_inv_addr = 20'h0_0042;
      reg_wr = 1; reg_sel = 2'd0; reg_wdata = 32'h5; cyc();
      reg_wr = 0; blk_inv_req = 0;
      idle(1);

      phase = "R11";
      core_done = 1; core_err = 1; core_err_kind = 1; cyc();
      core_done = 0; core_err = 0; core_err_kind = 0;
      rd_chk(2'd0, 1, 0);
      idle(2);

      summary();
   end
endmodule